// File: doc/BRIEF.md
# Shadow-Bit Page Color Renamer

This block renames physical addresses inside the processor so that a page can be given a new cache color without being copied in memory. A 64-bit address uses only its low 41 bits as a real physical address. The 23 bits above that are shadow bits, and they are zero in every ordinary address. On the inbound path the block receives a physical address together with the TLB entry fields for that page. If the page has been migrated, the block writes the new color into the color field. It moves the old color into the top of the shadow region and sets a marker bit below it. The result is an internal name that no ordinary address can collide with.

On the outbound path, used when an L2 miss must leave the chip, the block looks only at the shadow bits. A request with any shadow bit set gets its original color back from the shadow region, and its shadow bits are cleared. A request with a zero shadow field passes through unchanged. No table lookup is needed. Each TLB entry also carries a migrating bit. An access to such a page is refused with a stall indication, so the requester retries after the shootdown ends.

The color field sits at a parameterised position: 6 bits starting at bit 12 by default, for 4 KB pages. An elaboration check keeps the field above the L1 index bits, so virtually indexed L1 lookup is unaffected. Each path is combinational logic followed by one output register.

Top module: `pcolor_renamer`

## Requirements
- R1: During and right after synchronous reset, `int_valid`, `lk_stall` and `mem_valid` are 0.
- R2: An inbound request with `lk_migrated`=0 and `lk_migrating`=0 appears one cycle later on `int_addr` equal to `lk_paddr`, with `int_valid`=1.
- R3: An inbound request with `lk_migrated`=1 and `lk_migrating`=0 yields `int_addr[17:12]` = `lk_new_color`, with bits [11:0] and [40:18] equal to those of `lk_paddr`.
- R4: For that same renamed request, `int_addr[63:58]` holds the original color `lk_paddr[17:12]`, marker bit 57 is 1, and bits [56:41] are 0.
- R5: An inbound request with `lk_migrating`=1 gives `lk_stall`=1 and `int_valid`=0 one cycle later, whatever `lk_migrated` is.
- R6: An outbound request whose bits [63:41] are not all zero appears one cycle later on `mem_addr` with bits [17:12] taken from request bits [63:58], bits [63:41] cleared, and every other bit unchanged.
- R7: An outbound request whose bits [63:41] are all zero appears one cycle later on `mem_addr` unchanged.
- R8: Any address renamed on the inbound path, fed to the outbound path, comes back as the original physical address, including when the original color is 0.
- R9: Each path has one cycle of latency. With no request in a cycle, the matching valid and stall outputs are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Inbound request present |
| lk_paddr | input | 64 | Physical address from the TLB |
| lk_migrated | input | 1 | TLB entry: page has a new color |
| lk_new_color | input | 6 | TLB entry: new page color |
| lk_migrating | input | 1 | TLB entry: shootdown in progress |
| int_valid | output | 1 | Internal address valid |
| int_addr | output | 64 | Internal (possibly renamed) address |
| lk_stall | output | 1 | Request refused, retry later |
| miss_valid | input | 1 | Outbound request present |
| miss_addr | input | 64 | Internal address of the L2 miss |
| mem_valid | output | 1 | Off-chip address valid |
| mem_addr | output | 64 | Restored physical address |

## Verification
Corrupted state in the inbound register shows at the ports one cycle after the request. It appears as a wrong color field, a wrong shadow pattern, or a stall raised for a page that is not migrating. A fault in the outbound stage shows just as fast, as a nonzero shadow field or a wrong color on `mem_addr`. Round trips through both paths reveal mismatches between the two halves, such as the marker or color placement disagreeing. These include the original color 0, where a shadow field without a marker would read as an ordinary address.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int ADDR_W_DEF    = 64;
  localparam int PA_W_DEF      = 41;
  localparam int COLOR_W_DEF   = 6;
  localparam int COLOR_LSB_DEF = 12;
  localparam int L1_TOP_DEF    = 11;

  typedef enum logic [1:0] {
    IB_NONE   = 2'd0,
    IB_PASS   = 2'd1,
    IB_RENAME = 2'd2,
    IB_HOLD   = 2'd3
  } ib_kind_e;
endpackage

// File: rtl/pcr_stage.sv
module pcr_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  input  logic [W-1:0] d_data,
  output logic         q_valid,
  output logic [W-1:0] q_data
);
  always_ff @(posedge clk) begin
    if (rst) q_valid <= 1'b0;
    else     q_valid <= d_valid;
    q_data <= d_data;
  end
endmodule

// File: rtl/pcr_inbound.sv
module pcr_inbound
  import pcr_pkg::*;
#(
  parameter int ADDR_W    = ADDR_W_DEF,
  parameter int PA_W      = PA_W_DEF,
  parameter int COLOR_W   = COLOR_W_DEF,
  parameter int COLOR_LSB = COLOR_LSB_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_paddr,
  input  logic              lk_migrated,
  input  logic [COLOR_W-1:0] lk_new_color,
  input  logic              lk_migrating,
  output logic              int_valid,
  output logic [ADDR_W-1:0] int_addr,
  output logic              lk_stall
);
  localparam int SH_W     = ADDR_W - PA_W;
  localparam int MARK_BIT = ADDR_W - 1 - COLOR_W;
  localparam logic [ADDR_W-1:0] PA_MASK = {{SH_W{1'b0}}, {PA_W{1'b1}}};
  localparam logic [ADDR_W-1:0] CF_MASK =
    {{(ADDR_W-COLOR_LSB-COLOR_W){1'b0}}, {COLOR_W{1'b1}}, {COLOR_LSB{1'b0}}};
  localparam logic [ADDR_W-1:0] KEEP_MASK = PA_MASK & ~CF_MASK;

  ib_kind_e          kind;
  logic [ADDR_W-1:0] renamed;
  logic [ADDR_W-1:0] nxt_addr;
  logic              q_v;
  logic [ADDR_W:0]   q_d;

  always_comb begin
    if (!lk_valid)        kind = IB_NONE;
    else if (lk_migrating) kind = IB_HOLD;
    else if (lk_migrated)  kind = IB_RENAME;
    else                   kind = IB_PASS;
  end

  always_comb begin
    renamed = lk_paddr & PA_MASK;
    renamed[COLOR_LSB +: COLOR_W] = lk_new_color;
    renamed[ADDR_W-1 -: COLOR_W]  = lk_paddr[COLOR_LSB +: COLOR_W];
    renamed[MARK_BIT]             = 1'b1;
  end

  always_comb begin
    case (kind)
      IB_RENAME: nxt_addr = renamed;
      default:   nxt_addr = lk_paddr;
    endcase
  end

  pcr_stage #(.W(ADDR_W+1)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .d_valid (kind != IB_NONE),
    .d_data  ({kind == IB_HOLD, nxt_addr}),
    .q_valid (q_v),
    .q_data  (q_d)
  );

  assign int_valid = q_v & ~q_d[ADDR_W];
  assign lk_stall  = q_v &  q_d[ADDR_W];
  assign int_addr  = q_d[ADDR_W-1:0];

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!int_valid && !lk_stall));

  assert_pass_through_R2: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_migrating && !lk_migrated) |=>
      (int_valid && int_addr == $past(lk_paddr)));

  assert_new_color_R3: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_migrating && lk_migrated) |=>
      (int_valid && int_addr[COLOR_LSB +: COLOR_W] == $past(lk_new_color)
       && ((int_addr ^ $past(lk_paddr)) & KEEP_MASK) == '0));

  assert_shadow_color_R4: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !lk_migrating && lk_migrated) |=>
      (int_addr[ADDR_W-1 -: COLOR_W] == $past(lk_paddr[COLOR_LSB +: COLOR_W])
       && int_addr[MARK_BIT]));

  assert_stall_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && lk_migrating) |=> (lk_stall && !int_valid));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!int_valid && !lk_stall));
endmodule

// File: rtl/pcr_outbound.sv
module pcr_outbound
  import pcr_pkg::*;
#(
  parameter int ADDR_W    = ADDR_W_DEF,
  parameter int PA_W      = PA_W_DEF,
  parameter int COLOR_W   = COLOR_W_DEF,
  parameter int COLOR_LSB = COLOR_LSB_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam int SH_W = ADDR_W - PA_W;

  logic              has_shadow;
  logic [ADDR_W-1:0] restored;

  assign has_shadow = |miss_addr[ADDR_W-1:PA_W];

  always_comb begin
    restored = miss_addr;
    if (has_shadow) begin
      restored[COLOR_LSB +: COLOR_W] = miss_addr[ADDR_W-1 -: COLOR_W];
      restored[ADDR_W-1:PA_W]        = {SH_W{1'b0}};
    end
  end

  pcr_stage #(.W(ADDR_W)) u_stage (
    .clk     (clk),
    .rst     (rst),
    .d_valid (miss_valid),
    .d_data  (restored),
    .q_valid (mem_valid),
    .q_data  (mem_addr)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !mem_valid);

  assert_shadow_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_addr[ADDR_W-1:PA_W] != '0) |=>
      (mem_valid && mem_addr[ADDR_W-1:PA_W] == '0
       && mem_addr[COLOR_LSB +: COLOR_W] == $past(miss_addr[ADDR_W-1 -: COLOR_W])));

  assert_plain_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && miss_addr[ADDR_W-1:PA_W] == '0) |=>
      (mem_valid && mem_addr == $past(miss_addr)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !miss_valid |=> !mem_valid);
endmodule

// File: rtl/pcolor_renamer.sv
module pcolor_renamer
  import pcr_pkg::*;
#(
  parameter int ADDR_W    = ADDR_W_DEF,
  parameter int PA_W      = PA_W_DEF,
  parameter int COLOR_W   = COLOR_W_DEF,
  parameter int COLOR_LSB = COLOR_LSB_DEF,
  parameter int L1_TOP    = L1_TOP_DEF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lk_valid,
  input  logic [ADDR_W-1:0]  lk_paddr,
  input  logic               lk_migrated,
  input  logic [COLOR_W-1:0] lk_new_color,
  input  logic               lk_migrating,
  output logic               int_valid,
  output logic [ADDR_W-1:0]  int_addr,
  output logic               lk_stall,
  input  logic               miss_valid,
  input  logic [ADDR_W-1:0]  miss_addr,
  output logic               mem_valid,
  output logic [ADDR_W-1:0]  mem_addr
);
  localparam int SH_W = ADDR_W - PA_W;

  generate
    if (COLOR_LSB <= L1_TOP) begin : g_bad_l1
      $error("color field overlaps L1 index bits");
    end
    if (SH_W < COLOR_W + 1) begin : g_bad_shadow
      $error("shadow region too narrow for color and marker");
    end
    if (COLOR_LSB + COLOR_W > PA_W) begin : g_bad_color
      $error("color field outside physical address bits");
    end
  endgenerate

  pcr_inbound #(
    .ADDR_W(ADDR_W), .PA_W(PA_W), .COLOR_W(COLOR_W), .COLOR_LSB(COLOR_LSB)
  ) u_in (
    .clk          (clk),
    .rst          (rst),
    .lk_valid     (lk_valid),
    .lk_paddr     (lk_paddr),
    .lk_migrated  (lk_migrated),
    .lk_new_color (lk_new_color),
    .lk_migrating (lk_migrating),
    .int_valid    (int_valid),
    .int_addr     (int_addr),
    .lk_stall     (lk_stall)
  );

  pcr_outbound #(
    .ADDR_W(ADDR_W), .PA_W(PA_W), .COLOR_W(COLOR_W), .COLOR_LSB(COLOR_LSB)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .miss_valid (miss_valid),
    .miss_addr  (miss_addr),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr)
  );
endmodule

// File: tb/pcolor_renamer_tb.sv
module pcolor_renamer_tb;
  localparam int CLK_PERIOD = 10;
  localparam longint WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        lk_valid, lk_migrated, lk_migrating;
  logic [63:0] lk_paddr;
  logic [5:0]  lk_new_color;
  logic        int_valid, lk_stall;
  logic [63:0] int_addr;
  logic        miss_valid, mem_valid;
  logic [63:0] miss_addr, mem_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcolor_renamer u_dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_paddr(lk_paddr), .lk_migrated(lk_migrated),
    .lk_new_color(lk_new_color), .lk_migrating(lk_migrating),
    .int_valid(int_valid), .int_addr(int_addr), .lk_stall(lk_stall),
    .miss_valid(miss_valid), .miss_addr(miss_addr),
    .mem_valid(mem_valid), .mem_addr(mem_addr)
  );

  function automatic logic [63:0] exp_rename(logic [63:0] pa, logic [5:0] nc);
    logic [63:0] oc;
    oc = (pa >> 12) & 64'h3F;
    return (pa & 64'h0000_01FF_FFFC_0FFF) | ({58'd0, nc} << 12)
           | (oc << 58) | (64'd1 << 57);
  endfunction

  function automatic logic [63:0] exp_restore(logic [63:0] a);
    if ((a >> 41) == 64'd0) return a;
    return (a & 64'h0000_01FF_FFFC_0FFF) | (((a >> 58) & 64'h3F) << 12);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic idle_inputs();
    lk_valid = 0; lk_migrated = 0; lk_migrating = 0;
    lk_paddr = '0; lk_new_color = '0;
    miss_valid = 0; miss_addr = '0;
  endtask

  // Drive at negedge; registered result is visible at the following negedge.
  task automatic inbound(logic [63:0] pa, logic mig, logic [5:0] nc, logic busy);
    lk_valid = 1; lk_paddr = pa; lk_migrated = mig;
    lk_new_color = nc; lk_migrating = busy;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic outbound(logic [63:0] a);
    miss_valid = 1; miss_addr = a;
    @(negedge clk);
    idle_inputs();
  endtask

  function automatic logic [63:0] rand_pa();
    return {$urandom, $urandom} & 64'h0000_01FF_FFFF_FFFF;
  endfunction

  initial begin
    longint cyc = 0;
    while (cyc < WATCHDOG) begin
      @(posedge clk);
      cyc++;
    end
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, WATCHDOG);
    finish_run();
  end

  initial begin
    logic [63:0] pa, ren;
    logic [5:0]  nc;
    void'($urandom(32'd4711));
    idle_inputs();
    rst = 1;
    lk_valid = 1; lk_migrating = 1; miss_valid = 1; miss_addr = 64'h1;
    repeat (3) @(negedge clk);
    check("R1 int_valid in reset", {63'd0, int_valid}, 64'd0);
    check("R1 lk_stall in reset",  {63'd0, lk_stall},  64'd0);
    check("R1 mem_valid in reset", {63'd0, mem_valid}, 64'd0);
    idle_inputs();
    rst = 0;
    @(negedge clk);
    check("R1 int_valid after reset", {63'd0, int_valid}, 64'd0);

    // R2 unmigrated page
    pa = 64'h0000_0123_4567_89AB;
    inbound(pa, 0, 6'h15, 0);
    check("R2 int_valid", {63'd0, int_valid}, 64'd1);
    check("R2 int_addr", int_addr, pa);

    // R3/R4 migrated page
    pa = 64'h0000_01FF_FFFF_FFFF;
    inbound(pa, 1, 6'h00, 0);
    check("R3 renamed addr", int_addr, exp_rename(pa, 6'h00));
    check("R3 color field", {58'd0, int_addr[17:12]}, 64'd0);
    check("R4 shadow color", {58'd0, int_addr[63:58]}, 64'h3F);
    check("R4 marker and gap", {48'd0, int_addr[57:41]}, 64'h10000);

    // R5 stall, with and without migrated flag
    inbound(pa, 1, 6'h2A, 1);
    check("R5 stall", {63'd0, lk_stall}, 64'd1);
    check("R5 no valid", {63'd0, int_valid}, 64'd0);
    inbound(pa, 0, 6'h2A, 1);
    check("R5 stall unmigrated", {62'd0, lk_stall, int_valid}, 64'd2);

    // R9 idle cycle
    @(negedge clk);
    check("R9 idle inbound", {62'd0, int_valid, lk_stall}, 64'd0);
    check("R9 idle outbound", {63'd0, mem_valid}, 64'd0);

    // R7 zero-shadow outbound
    pa = 64'h0000_0000_0003_F000;
    outbound(pa);
    check("R7 mem_valid", {63'd0, mem_valid}, 64'd1);
    check("R7 mem_addr", mem_addr, pa);

    // R6 outbound with shadow set
    outbound(64'hA800_0000_0000_0ABC);
    check("R6 restore", mem_addr, 64'h0000_0000_0002_AABC);

    // R8 original color 0 round trip
    pa = 64'h0000_0100_0000_0123;
    inbound(pa, 1, 6'h3F, 0);
    ren = int_addr;
    outbound(ren);
    check("R8 color0 round trip", mem_addr, pa);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      pa = rand_pa();
      nc = 6'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        inbound(pa, 1, nc, 0);
        check("R3 random rename", int_addr, exp_rename(pa, nc));
        ren = int_addr;
        outbound(ren);
        check("R8 random round trip", mem_addr, pa);
      end else begin
        inbound(pa, 0, nc, 0);
        check("R2 random pass", int_addr, pa);
        outbound(pa);
        check("R7 random pass", mem_addr, exp_restore(pa));
      end
    end

    finish_run();
  end
endmodule